// File: doc/BRIEF.md
# Burst SPI Master

A register-mapped SPI master that performs one complete chip-select burst for each start command. Software programs a total byte count for the burst and a smaller or equal count of bytes to transmit. It queues those transmit bytes in a transmit FIFO and then sets the exchange bit in the control register. The block lowers chip select, shifts the queued bytes out MSB first in SPI mode 0, and then keeps clocking filler bytes of 0xFF until the total count is reached. Every byte that arrives on MISO goes into a receive FIFO, including the bytes clocked while the command bytes are still going out. Software then drains that FIFO.

A typical use is a serial flash read. A 4-byte read command with a 3-byte address is followed by data bytes. Software discards the first four received bytes and keeps the rest. Both FIFOs hold 64 bytes, so the largest single burst of 4 command bytes plus 60 data bytes fits in the receive FIFO. The SCLK rate comes from a programmable divider on the system clock. The block also provides per-FIFO flush bits and a self-clearing soft reset.

Top module: `burst_spi_master`

## Requirements
- R1: After reset, chip select is high, SCLK is low, the control register reads 0, the status register reads 0 and the clock divider register reads 1.
- R2: A burst keeps chip select low for exactly the programmed total byte count. It produces 8 SCLK rising edges per byte, and SCLK is low whenever chip select is high.
- R3: The first send-count bytes of a burst are the transmit FIFO bytes in push order, MSB first. MOSI does not change on a cycle where SCLK rises (mode 0).
- R4: Every byte past the send count is driven on MOSI as 0xFF.
- R5: Every byte clocked in from MISO during a burst is stored in the receive FIFO in arrival order. Status bits [6:0] give the receive FIFO level, and a 64-byte burst leaves it at 64.
- R6: Writing control with bit 10 (exchange), bit 0 (enable) and bit 1 (master) all set, while a nonzero total count is programmed, starts a burst. Bit 10 reads 1 while the burst runs and clears itself in the cycle chip select rises. A start write that lacks enable or master is ignored.
- R7: If the transmit FIFO is empty when a byte below the send count is due, SCLK stays low with chip select held low until software pushes the byte. The burst then completes normally.
- R8: A divider value d gives an SCLK high phase of exactly d+1 system clocks. The default value 1 divides the system clock by 4.
- R9: Writing control bit 8 empties the transmit FIFO and writing bit 9 empties the receive FIFO. Both bits read back 0.
- R10: Writing control bit 31 starts a soft reset. The bit reads 1 for 4 cycles and then clears itself. The soft reset empties both FIFOs, aborts a running burst (chip select goes high) and clears bit 10.
- R11: A push into a full transmit FIFO is dropped, and status bits [14:8] stay at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at offset 0x14) |
| bus_addr | input | 5 | Byte offset: 0x00 control, 0x04 divider, 0x08 total count, 0x0C send count, 0x10 TX data, 0x14 RX data, 0x18 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Two operations can hit the receive FIFO in the same cycle: the shift engine pushes a finished byte, and software pops the oldest byte. The bench sets the divider to 0 so that the high phase lasts one clock. It counts SCLK rising edges and drives a receive-data read so that the pop lands on the exact clock where the eighth rising edge of each later byte ends and the push occurs. The result is judged by the popped bytes arriving in order from the scoreboard and by the level holding at 1 through the collisions.

// File: rtl/bspi_pkg.sv
package bspi_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] A_CLKDIV = 5'h04;
    localparam logic [ADDR_W-1:0] A_BURST  = 5'h08;
    localparam logic [ADDR_W-1:0] A_SEND   = 5'h0C;
    localparam logic [ADDR_W-1:0] A_TXDATA = 5'h10;
    localparam logic [ADDR_W-1:0] A_RXDATA = 5'h14;
    localparam logic [ADDR_W-1:0] A_STATUS = 5'h18;

    localparam int CB_EN     = 0;
    localparam int CB_MASTER = 1;
    localparam int CB_TXRST  = 8;
    localparam int CB_RXRST  = 9;
    localparam int CB_XCH    = 10;
    localparam int CB_SRST   = 31;

    localparam int STAT_TX_LSB = 8;

    localparam logic [7:0] FILLER = 8'hFF;

    typedef enum logic [2:0] {
        E_IDLE,
        E_LEAD,
        E_LOAD,
        E_LOW,
        E_HIGH,
        E_TRAIL
    } eng_state_t;

    typedef struct packed {
        logic srst;
        logic xch;
        logic master;
        logic en;
    } ctrl_t;

    function automatic logic [BUS_W-1:0] pack_ctrl(input ctrl_t c);
        logic [BUS_W-1:0] r;
        r            = '0;
        r[CB_EN]     = c.en;
        r[CB_MASTER] = c.master;
        r[CB_XCH]    = c.xch;
        r[CB_SRST]   = c.srst;
        return r;
    endfunction

endpackage

// File: rtl/bspi_fifo.sv
module bspi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (level == '0);
        full    = (level == LVL_W'(DEPTH));
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        head    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= adv(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= adv(rd_ptr);
            end
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end
endmodule

// File: rtl/bspi_engine.sv
module bspi_engine
    import bspi_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] burst,
    input  logic [CNT_W-1:0] send,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    output logic             done,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    eng_state_t       state;
    logic [DIV_W-1:0] cnt;
    logic [CNT_W-1:0] byte_idx, burst_l, send_l;
    logic [2:0]       bit_idx;
    logic [7:0]       sh, rx_sh;
    logic             tick, need_tx, last_byte;

    always_comb begin
        tick      = (cnt == div);
        need_tx   = (byte_idx < send_l);
        last_byte = (byte_idx == burst_l - 1'b1);
        tx_pop    = (state == E_LOAD) && need_tx && tx_valid;
        rx_push   = (state == E_HIGH) && tick && (bit_idx == 3'd7);
        done      = (state == E_TRAIL) && tick;
        rx_data   = rx_sh;
        sclk      = (state == E_HIGH);
        cs_n      = (state == E_IDLE);
        mosi      = sh[7];
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state    <= E_IDLE;
            cnt      <= '0;
            byte_idx <= '0;
            burst_l  <= '0;
            send_l   <= '0;
            bit_idx  <= '0;
            sh       <= '0;
            rx_sh    <= '0;
        end else begin
            case (state)
                E_IDLE: begin
                    if (start) begin
                        state    <= E_LEAD;
                        cnt      <= '0;
                        byte_idx <= '0;
                        burst_l  <= burst;
                        send_l   <= send;
                    end
                end
                E_LEAD: begin
                    if (tick) begin
                        state <= E_LOAD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                E_LOAD: begin
                    cnt     <= '0;
                    bit_idx <= '0;
                    if (need_tx) begin
                        if (tx_valid) begin
                            sh    <= tx_data;
                            state <= E_LOW;
                        end
                    end else begin
                        sh    <= FILLER;
                        state <= E_LOW;
                    end
                end
                E_LOW: begin
                    if (tick) begin
                        rx_sh <= {rx_sh[6:0], miso};
                        state <= E_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                E_HIGH: begin
                    if (tick) begin
                        cnt <= '0;
                        sh  <= {sh[6:0], 1'b0};
                        if (bit_idx == 3'd7) begin
                            byte_idx <= byte_idx + 1'b1;
                            state    <= last_byte ? E_TRAIL : E_LOAD;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            state   <= E_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                E_TRAIL: begin
                    if (tick) begin
                        state <= E_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bspi_regs.sv
module bspi_regs
    import bspi_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DIV_W       = 8,
    parameter int LVL_W       = 7,
    parameter int DIV_RESET   = 1,
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              eng_done,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [7:0]        rx_head,
    output logic              start,
    output logic              srst_active,
    output logic              xch,
    output logic [DIV_W-1:0]  div,
    output logic [CNT_W-1:0]  burst,
    output logic [CNT_W-1:0]  send,
    output logic              tx_push,
    output logic              rx_pop,
    output logic              tx_flush,
    output logic              rx_flush
);
    localparam int SC_W = $clog2(SRST_CYCLES + 1);

    ctrl_t           ctrl;
    logic [SC_W-1:0] srst_cnt;
    logic            wr_ctrl;

    always_comb begin
        wr_ctrl     = bus_wr && (bus_addr == A_CTRL);
        start       = wr_ctrl && bus_wdata[CB_XCH] && bus_wdata[CB_EN] &&
                      bus_wdata[CB_MASTER] && !ctrl.xch && !ctrl.srst &&
                      (burst != '0);
        tx_push     = bus_wr && (bus_addr == A_TXDATA);
        rx_pop      = bus_rd && (bus_addr == A_RXDATA);
        tx_flush    = (wr_ctrl && bus_wdata[CB_TXRST]) || ctrl.srst;
        rx_flush    = (wr_ctrl && bus_wdata[CB_RXRST]) || ctrl.srst;
        srst_active = ctrl.srst;
        xch         = ctrl.xch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            srst_cnt <= '0;
            div      <= DIV_W'(DIV_RESET);
            burst    <= '0;
            send     <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en     <= bus_wdata[CB_EN];
                ctrl.master <= bus_wdata[CB_MASTER];
            end
            if (bus_wr && bus_addr == A_CLKDIV) div   <= bus_wdata[DIV_W-1:0];
            if (bus_wr && bus_addr == A_BURST)  burst <= bus_wdata[CNT_W-1:0];
            if (bus_wr && bus_addr == A_SEND)   send  <= bus_wdata[CNT_W-1:0];

            if (ctrl.srst) begin
                srst_cnt <= srst_cnt + 1'b1;
                if (srst_cnt == SC_W'(SRST_CYCLES - 1)) ctrl.srst <= 1'b0;
            end else if (wr_ctrl && bus_wdata[CB_SRST]) begin
                ctrl.srst <= 1'b1;
                srst_cnt  <= '0;
            end

            if (ctrl.srst || eng_done) ctrl.xch <= 1'b0;
            else if (start)            ctrl.xch <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata = pack_ctrl(ctrl);
            A_CLKDIV: bus_rdata[DIV_W-1:0] = div;
            A_BURST:  bus_rdata[CNT_W-1:0] = burst;
            A_SEND:   bus_rdata[CNT_W-1:0] = send;
            A_RXDATA: bus_rdata[7:0] = rx_head;
            A_STATUS: begin
                bus_rdata[LVL_W-1:0]            = rx_level;
                bus_rdata[STAT_TX_LSB +: LVL_W] = tx_level;
            end
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/burst_spi_master.sv
module burst_spi_master
    import bspi_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int CNT_W       = 8,
    parameter int DIV_W       = 8,
    parameter int DIV_RESET   = 1,
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic             start, srst_active, xch_flag, eng_done;
    logic [DIV_W-1:0] clk_div;
    logic [CNT_W-1:0] burst_cnt, send_cnt;
    logic             tx_push, rx_pop, tx_flush, rx_flush;
    logic             tx_pop, tx_empty, tx_full, rx_push, rx_empty, rx_full;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic [LVL_W-1:0] tx_level, rx_level;

    bspi_regs #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .LVL_W(LVL_W),
        .DIV_RESET(DIV_RESET), .SRST_CYCLES(SRST_CYCLES)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .rx_level(rx_level), .tx_level(tx_level),
        .rx_head(rx_head), .start(start), .srst_active(srst_active),
        .xch(xch_flag), .div(clk_div), .burst(burst_cnt), .send(send_cnt),
        .tx_push(tx_push), .rx_pop(rx_pop),
        .tx_flush(tx_flush), .rx_flush(rx_flush)
    );

    bspi_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(tx_push), .push_data(bus_wdata[7:0]),
        .pop(tx_pop), .head(tx_head),
        .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    bspi_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_push), .push_data(rx_byte),
        .pop(rx_pop), .head(rx_head),
        .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    bspi_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst(rst), .abort(srst_active), .start(start),
        .div(clk_div), .burst(burst_cnt), .send(send_cnt),
        .tx_valid(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_byte), .done(eng_done),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
    );

    logic unused_flags;
    assign unused_flags = tx_full ^ rx_full ^ rx_empty;
endmodule

// File: rtl/bspi_checker.sv
module bspi_checker #(
    parameter int FIFO_DEPTH  = 64,
    parameter int LVL_W       = 7,
    parameter int DIV_W       = 8,
    parameter int SRST_CYCLES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sclk,
    input logic             cs_n,
    input logic             mosi,
    input logic             xch,
    input logic             srst,
    input logic [LVL_W-1:0] rx_level,
    input logic [DIV_W-1:0] div
);
    logic [DIV_W:0] hcnt;
    logic [31:0]    scnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            scnt <= '0;
        end else begin
            hcnt <= sclk ? hcnt + 1'b1 : '0;
            scnt <= srst ? scnt + 1 : '0;
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (rst || srst)
        $rose(sclk) |-> $stable(mosi));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        rx_level <= LVL_W'(FIFO_DEPTH));

    p_xch_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> !xch);

    p_high_width_r8: assert property (@(posedge clk) disable iff (rst || srst)
        $fell(sclk) |-> (hcnt == (DIV_W+1)'(div) + 1'b1));

    p_srst_len_r10: assert property (@(posedge clk) disable iff (rst)
        srst |-> (scnt < 32'(SRST_CYCLES)));
endmodule

bind burst_spi_master bspi_checker #(
    .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .DIV_W(DIV_W),
    .SRST_CYCLES(SRST_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .xch(xch_flag), .srst(srst_active),
    .rx_level(rx_level), .div(clk_div)
);

// File: tb/burst_spi_master_bench.sv
module burst_spi_master_bench;
    import bspi_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0, errors = 0, cycles = 0;
    int tag = 0, rise_cnt = 0, hrun = 0, hi_w = 0;
    logic [7:0] tx_pat [64];
    logic [7:0] exp_mosi [$];
    logic [7:0] exp_rx [$];
    logic [7:0] mo_sh = '0, so_sh = '0;
    int bitn = 0, sidx = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    burst_spi_master u_burst_spi_master (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    function automatic logic [7:0] resp(input int t, input int k);
        return 8'h5A ^ 8'(t * 17) ^ 8'(k * 29);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // slave model and MOSI scoreboard monitor
    always @(negedge spi_cs_n) begin
        bitn = 0; sidx = 0;
        so_sh = resp(tag, 0);
        spi_miso = so_sh[7];
    end
    always @(posedge spi_sclk) begin
        rise_cnt++;
        mo_sh = {mo_sh[6:0], spi_mosi};
        bitn++;
        if (bitn == 8) begin
            bitn = 0;
            sidx++;
            if (exp_mosi.size() == 0) chk(0, "R3", "unexpected mosi byte", mo_sh, 0);
            else begin
                logic [7:0] e;
                e = exp_mosi.pop_front();
                chk(mo_sh == e, "R3/R4", "mosi byte", mo_sh, e);
            end
        end
    end
    always @(negedge spi_sclk) begin
        if (bitn == 0) so_sh = resp(tag, sidx);
        else           so_sh = {so_sh[6:0], 1'b0};
        spi_miso = so_sh[7];
    end
    always @(negedge clk) begin
        if (spi_sclk) hrun++;
        else begin
            if (hrun != 0) hi_w = hrun;
            hrun = 0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 199000 && !finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_burst(input int burst, input int send, input int npush);
        tag++;
        for (int k = 0; k < burst; k++) begin
            exp_mosi.push_back(k < send ? tx_pat[k] : 8'hFF);
            exp_rx.push_back(resp(tag, k));
        end
        bus_write(A_BURST, 32'(burst));
        bus_write(A_SEND, 32'(send));
        for (int k = 0; k < npush; k++) bus_write(A_TXDATA, {24'h0, tx_pat[k]});
        rise_cnt = 0;
        bus_write(A_CTRL, 32'h0000_0403);
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 20000; i++) begin
            bus_read(A_CTRL, d);
            if (!d[CB_XCH]) break;
        end
    endtask

    task automatic drain_rx(input int n, input string req);
        logic [31:0] d;
        for (int k = 0; k < n; k++) begin
            logic [7:0] e;
            e = (exp_rx.size() != 0) ? exp_rx.pop_front() : 8'h00;
            bus_read(A_RXDATA, d);
            chk(d[7:0] == e, req, "rx byte", d[7:0], e);
        end
    endtask

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1", "cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1", "sclk", spi_sclk, 0);
        bus_read(A_CTRL, d);   chk(d == 0, "R1", "ctrl", d, 0);
        bus_read(A_STATUS, d); chk(d == 0, "R1", "status", d, 0);
        bus_read(A_CLKDIV, d); chk(d == 1, "R1", "divider", d, 1);

        // read-command style burst: 4 sent, 4 filler
        tx_pat[0] = 8'h03; tx_pat[1] = 8'h12; tx_pat[2] = 8'h34; tx_pat[3] = 8'h56;
        run_burst(8, 4, 4);
        bus_read(A_CTRL, d);
        chk(d[CB_XCH] == 1'b1, "R6", "exchange bit while busy", d[CB_XCH], 1);
        wait_idle();
        chk(spi_cs_n == 1'b1, "R6", "cs_n after burst", spi_cs_n, 1);
        chk(rise_cnt == 64, "R2", "sclk rises", rise_cnt, 64);
        chk(hi_w == 2, "R8", "default high phase", hi_w, 2);
        chk(exp_mosi.size() == 0, "R4", "mosi bytes left", exp_mosi.size(), 0);
        bus_read(A_STATUS, d);
        chk(d[6:0] == 8, "R5", "rx level", d[6:0], 8);
        drain_rx(8, "R5");

        // all bytes sent, none filler
        tx_pat[0] = 8'hA1; tx_pat[1] = 8'hB2; tx_pat[2] = 8'hC3;
        run_burst(3, 3, 3);
        wait_idle();
        chk(rise_cnt == 24, "R2", "sclk rises", rise_cnt, 24);
        drain_rx(3, "R5");

        // largest burst fills the receive FIFO
        tx_pat[0] = 8'h03; tx_pat[1] = 8'h00; tx_pat[2] = 8'h10; tx_pat[3] = 8'h00;
        run_burst(64, 4, 4);
        wait_idle();
        bus_read(A_STATUS, d);
        chk(d[6:0] == 64, "R5", "full rx level", d[6:0], 64);
        drain_rx(64, "R5");

        // push and pop on the same cycle
        bus_write(A_CLKDIV, 32'd0);
        tx_pat[0] = 8'h9A; tx_pat[1] = 8'h5B;
        run_burst(6, 2, 2);
        for (int k = 1; k < 6; k++) begin
            logic [7:0] e;
            wait (rise_cnt == 8 * (k + 1));
            e = exp_rx.pop_front();
            bus_read(A_RXDATA, d);
            chk(d[7:0] == e, "R5", "rx byte under collision", d[7:0], e);
        end
        wait (spi_cs_n == 1'b1);
        wait_idle();
        bus_read(A_STATUS, d);
        chk(d[6:0] == 1, "R5", "level after collisions", d[6:0], 1);
        drain_rx(1, "R5");

        // divider 3 gives four-clock high phase
        bus_write(A_CLKDIV, 32'd3);
        tx_pat[0] = 8'h81;
        run_burst(2, 1, 1);
        wait_idle();
        chk(hi_w == 4, "R8", "high phase for divider 3", hi_w, 4);
        drain_rx(2, "R5");
        bus_write(A_CLKDIV, 32'd1);

        // start without enable or master is ignored
        bus_write(A_BURST, 32'd2);
        bus_write(A_CTRL, 32'h0000_0400);
        repeat (20) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R6", "cs_n after gated start", spi_cs_n, 1);
        bus_read(A_CTRL, d);
        chk(d[CB_XCH] == 1'b0, "R6", "exchange after gated start", d[CB_XCH], 0);
        bus_write(A_CTRL, 32'h0000_0401);
        repeat (20) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R6", "cs_n without master", spi_cs_n, 1);

        // transmit underflow stalls the clock
        tx_pat[0] = 8'h11; tx_pat[1] = 8'h22; tx_pat[2] = 8'h33;
        run_burst(3, 3, 1);
        repeat (200) @(negedge clk);
        chk(rise_cnt == 8, "R7", "rises during stall", rise_cnt, 8);
        chk(spi_cs_n == 1'b0, "R7", "cs_n held during stall", spi_cs_n, 0);
        chk(spi_sclk == 1'b0, "R7", "sclk low during stall", spi_sclk, 0);
        bus_write(A_TXDATA, {24'h0, tx_pat[1]});
        bus_write(A_TXDATA, {24'h0, tx_pat[2]});
        wait_idle();
        chk(rise_cnt == 24, "R7", "rises after refill", rise_cnt, 24);
        drain_rx(3, "R7");

        // FIFO flush bits
        for (int k = 0; k < 3; k++) bus_write(A_TXDATA, 32'h0000_00EE);
        bus_read(A_STATUS, d);
        chk(d[14:8] == 3, "R9", "tx level before flush", d[14:8], 3);
        bus_write(A_CTRL, 32'h0000_0103);
        bus_read(A_STATUS, d);
        chk(d[14:8] == 0, "R9", "tx level after flush", d[14:8], 0);
        bus_read(A_CTRL, d);
        chk(d == 32'h3, "R9", "ctrl readback", d, 3);
        run_burst(2, 0, 0);
        wait_idle();
        bus_write(A_CTRL, 32'h0000_0203);
        bus_read(A_STATUS, d);
        chk(d[6:0] == 0, "R9", "rx level after flush", d[6:0], 0);
        exp_rx.delete();

        // full transmit FIFO drops extra pushes
        for (int k = 0; k < 70; k++) bus_write(A_TXDATA, 32'(k));
        bus_read(A_STATUS, d);
        chk(d[14:8] == 64, "R11", "tx level at full", d[14:8], 64);
        bus_write(A_CTRL, 32'h0000_0103);

        // soft reset aborts a burst
        run_burst(20, 0, 0);
        wait (rise_cnt >= 12);
        bus_write(A_CTRL, 32'h8000_0003);
        bus_read(A_CTRL, d);
        chk(d[CB_SRST] == 1'b1, "R10", "soft reset bit set", d[CB_SRST], 1);
        repeat (10) @(negedge clk);
        bus_read(A_CTRL, d);
        chk(d[CB_SRST] == 1'b0, "R10", "soft reset bit cleared", d[CB_SRST], 0);
        chk(d[CB_XCH] == 1'b0, "R10", "exchange cleared", d[CB_XCH], 0);
        chk(spi_cs_n == 1'b1, "R10", "cs_n after abort", spi_cs_n, 1);
        bus_read(A_STATUS, d);
        chk(d == 0, "R10", "status after soft reset", d, 0);
        exp_mosi.delete();
        exp_rx.delete();

        // normal burst after soft reset
        tx_pat[0] = 8'h3C;
        run_burst(2, 1, 1);
        wait_idle();
        chk(rise_cnt == 16, "R2", "rises after soft reset", rise_cnt, 16);
        drain_rx(2, "R5");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule